// File: doc/BRIEF.md
# Dual-Bank Pair-Load Unit

This unit carries out 32-bit load instructions for an accelerator with two register files, A and B. Each file owns one data memory bank and four pointer registers. A load takes the word at the address held in the chosen pointer and splits it across an even/odd pair of 16-bit data registers. It can then step the pointer up or down by one word. File A and file B each have their own lane, so one load per file can issue in every cycle and both can issue in the same cycle. The core uses one port of each bank. The second port of each bank is left free for a DMA engine, so DMA traffic never stalls a load.

Each lane contains a three-state machine. `LN_IDLE` means no result is pending. `LN_FILL` means a legal load issued in the previous cycle and its memory word is now being written back. `LN_FAULT` means an issued load named an illegal destination. The state is recomputed in every cycle from that cycle's issue:
- `GO_FILL` is taken on a legal issue.
- `GO_FAULT` is taken on an illegal issue.
- `GO_IDLE` is taken when nothing issues.

All three transitions can be taken from any of the three states. Pointers are loaded through a separate setup port. The data registers can be read at any time through a combinational read port on each file.

Top module: `pl_dual_load`

## Requirements
- R1: After reset, all twelve data registers read 0 and all pointers are 0. Both error outputs and both memory read enables are low.
- R2: A legal load raises the lane's `*_mem_re` in its issue cycle. In the same cycle, `*_mem_addr` equals the selected pointer's value before any update.
- R3: The memory returns data one cycle after the read. That word is written to the destination pair on the next clock edge. Bits [15:0] go to register `dst`, and bits [31:16` go to register `dst+1`.
- R4: The modifier field works as follows: 2'b01 adds 1 to the selected pointer, 2'b10 subtracts 1, and 2'b00 or 2'b11 leaves it unchanged. Arithmetic wraps modulo 2^AW, and the update takes effect on the issue edge.
- R5: A destination field that is odd or greater than 4 (1, 3, 5, 6 or 7) is illegal. For an illegal issue, the lane's error output is high for exactly the cycle after the issue. The lane does not read memory, does not modify any data register and does not change its pointer.
- R6: Loads on lanes A and B in the same cycle are independent. Each lane uses only its own pointers, bank and registers.
- R7: A setup write (`cfg_bank` 0 = A, 1 = B) loads `cfg_val` into the chosen pointer on the next edge. If the same pointer is post-modified in that cycle, the setup value wins.
- R8: A lane accepts a new load in every cycle. A load issued directly after another one does not disturb the earlier writeback.
- R9: A load writes only its own two destination registers. The other registers in that file keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Pointer setup write strobe |
| cfg_bank | input | 1 | Setup target file (0 = A, 1 = B) |
| cfg_idx | input | 2 | Setup target pointer index |
| cfg_val | input | AW | Setup value |
| a_issue | input | 1 | Issue a load on file A |
| a_dst | input | 3 | Destination even register for A |
| a_ptr | input | 2 | Pointer select for A |
| a_mod | input | 2 | Post-modify code for A |
| b_issue | input | 1 | Issue a load on file B |
| b_dst | input | 3 | Destination even register for B |
| b_ptr | input | 2 | Pointer select for B |
| b_mod | input | 2 | Post-modify code for B |
| a_mem_re | output | 1 | Bank A core-port read enable |
| a_mem_addr | output | AW | Bank A core-port word address |
| a_mem_rdata | input | 32 | Bank A read data, one cycle after the read |
| b_mem_re | output | 1 | Bank B core-port read enable |
| b_mem_addr | output | AW | Bank B core-port word address |
| b_mem_rdata | input | 32 | Bank B read data, one cycle after the read |
| a_err | output | 1 | Illegal-destination flag for A |
| b_err | output | 1 | Illegal-destination flag for B |
| a_rd_idx | input | 3 | File A register read index |
| a_rd_data | output | 16 | File A register read data |
| b_rd_idx | input | 3 | File B register read index |
| b_rd_data | output | 16 | File B register read data |

## Verification
The bench targets the following corner cases and the faults each one exposes:
- **Pointer wrap.** Incrementing a pointer at the top of the address range must give 0, and decrementing 0 must give the top address. A design with the wrong carry width would jump to an unrelated address.
- **Illegal destinations.** The codes 1, 3, 5, 6 and 7 are each issued. A decoder that only checks the low bit would accept 6 and overwrite registers beyond the pair range.
- **Setup and post-modify on one pointer in one cycle.** A design that gives priority to the modify would lose the setup value.
- **Back-to-back and cross-lane issues.** These catch a writeback that uses the wrong pair, the wrong half-word order or the other bank's data.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [1:0] {
        MOD_NONE = 2'b00,
        MOD_INC  = 2'b01,
        MOD_DEC  = 2'b10,
        MOD_HOLD = 2'b11
    } mod_e;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'b00,
        LN_FILL  = 2'b01,
        LN_FAULT = 2'b10
    } lane_state_e;

    localparam int NUM_PTR  = 4;
    localparam int NUM_REG  = 6;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
endpackage

// File: rtl/pl_lane.sv
module pl_lane
    import pl_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue,
    input  logic [2:0]                   dst,
    input  logic [1:0]                   ptr_sel,
    input  logic [1:0]                   mod,
    input  logic                         set_we,
    input  logic [1:0]                   set_idx,
    input  logic [AW-1:0]                set_val,
    output logic                         mem_re,
    output logic [AW-1:0]                mem_addr,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         wb_en,
    output logic [1:0]                   wb_pair,
    output logic [WORD_W-1:0]            wb_data,
    output logic                         err
);
    localparam int LAST_REG = NUM_REG - 2;

    lane_state_e        state_q, state_d;
    logic [AW-1:0]      ptr_q [NUM_PTR];
    logic [1:0]         pair_q;
    logic               legal;

    // Destination must be even and name one of the three pairs.
    always_comb begin
        legal = issue && !dst[0] && (int'(dst) <= LAST_REG);
    end

    // Next-state logic: every state has the same three exits.
    always_comb begin
        state_d = LN_IDLE;
        unique case (state_q)
            LN_IDLE, LN_FILL, LN_FAULT: begin
                if (issue && legal)      state_d = LN_FILL;   // GO_FILL
                else if (issue)          state_d = LN_FAULT;  // GO_FAULT
                else                     state_d = LN_IDLE;   // GO_IDLE
            end
            default:                     state_d = LN_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            pair_q  <= '0;
        end else begin
            state_q <= state_d;
            if (legal) pair_q <= dst[2:1];
        end
    end

    // Pointer file: setup write has priority over post-modify.
    generate
        for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q[p] <= '0;
                end else if (set_we && set_idx == 2'(p)) begin
                    ptr_q[p] <= set_val;
                end else if (legal && ptr_sel == 2'(p)) begin
                    unique case (mod_e'(mod))
                        MOD_INC:            ptr_q[p] <= ptr_q[p] + 1'b1;
                        MOD_DEC:            ptr_q[p] <= ptr_q[p] - 1'b1;
                        MOD_NONE, MOD_HOLD: ptr_q[p] <= ptr_q[p];
                        default:            ptr_q[p] <= ptr_q[p];
                    endcase
                end
            end
        end
    endgenerate

    // Outputs decoded from state and issue.
    always_comb begin
        mem_re   = legal;
        mem_addr = ptr_q[ptr_sel];
        wb_en    = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            LN_IDLE:  ;
            LN_FILL:  wb_en = 1'b1;
            LN_FAULT: err   = 1'b1;
            default:  ;
        endcase
        wb_pair = pair_q;
        wb_data = mem_rdata;
    end

    AST_FILL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(mem_re)) else $error("fill without read"); // R3
    AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(mem_re)) else $error("fault after read"); // R5
    AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mod == MOD_INC && !(set_we && set_idx == ptr_sel))
        |=> ptr_q[$past(ptr_sel)] == $past(mem_addr) + 1'b1) else $error("inc"); // R4
    AST_PTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mod == MOD_DEC && !(set_we && set_idx == ptr_sel))
        |=> ptr_q[$past(ptr_sel)] == $past(mem_addr) - 1'b1) else $error("dec"); // R4
    AST_SETUP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ptr_q[$past(set_idx)] == $past(set_val)) else $error("setup"); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !mem_re) |=> err) else $error("missing error"); // R5
endmodule

// File: rtl/pl_pairfile.sv
module pl_pairfile
    import pl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wb_en,
    input  logic [1:0]             wb_pair,
    input  logic [WORD_W-1:0]      wb_data,
    input  logic [2:0]             rd_idx,
    output logic [HALF_W-1:0]      rd_data
);
    localparam int NUM_PAIR = NUM_REG / 2;

    logic [HALF_W-1:0] regs_q [NUM_REG];

    generate
        for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[2*k]   <= '0;
                    regs_q[2*k+1] <= '0;
                end else if (wb_en && wb_pair == 2'(k)) begin
                    regs_q[2*k]   <= wb_data[HALF_W-1:0];
                    regs_q[2*k+1] <= wb_data[WORD_W-1:HALF_W];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_REG) rd_data = regs_q[rd_idx];
    end

    AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> int'(wb_pair) < NUM_PAIR) else $error("pair range"); // R3
endmodule

// File: rtl/pl_dual_load.sv
module pl_dual_load
    import pl_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [1:0]        cfg_idx,
    input  logic [AW-1:0]     cfg_val,
    input  logic              a_issue,
    input  logic [2:0]        a_dst,
    input  logic [1:0]        a_ptr,
    input  logic [1:0]        a_mod,
    input  logic              b_issue,
    input  logic [2:0]        b_dst,
    input  logic [1:0]        b_ptr,
    input  logic [1:0]        b_mod,
    output logic              a_mem_re,
    output logic [AW-1:0]     a_mem_addr,
    input  logic [31:0]       a_mem_rdata,
    output logic              b_mem_re,
    output logic [AW-1:0]     b_mem_addr,
    input  logic [31:0]       b_mem_rdata,
    output logic              a_err,
    output logic              b_err,
    input  logic [2:0]        a_rd_idx,
    output logic [15:0]       a_rd_data,
    input  logic [2:0]        b_rd_idx,
    output logic [15:0]       b_rd_data
);
    localparam int NUM_LANE = 2;

    logic [NUM_LANE-1:0]   iss, re, err, wbe;
    logic [2:0]            dst   [NUM_LANE];
    logic [2:0]            ridx  [NUM_LANE];
    logic [1:0]            psel  [NUM_LANE];
    logic [1:0]            pmod  [NUM_LANE];
    logic [1:0]            wpair [NUM_LANE];
    logic [AW-1:0]         addr  [NUM_LANE];
    logic [WORD_W-1:0]     rdat  [NUM_LANE];
    logic [WORD_W-1:0]     wdat  [NUM_LANE];
    logic [HALF_W-1:0]     rout  [NUM_LANE];

    assign iss     = {b_issue, a_issue};
    assign dst[0]  = a_dst;   assign dst[1]  = b_dst;
    assign psel[0] = a_ptr;   assign psel[1] = b_ptr;
    assign pmod[0] = a_mod;   assign pmod[1] = b_mod;
    assign rdat[0] = a_mem_rdata; assign rdat[1] = b_mem_rdata;
    assign ridx[0] = a_rd_idx; assign ridx[1] = b_rd_idx;

    generate
        for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
            pl_lane #(.AW(AW)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue     (iss[l]),
                .dst       (dst[l]),
                .ptr_sel   (psel[l]),
                .mod       (pmod[l]),
                .set_we    (cfg_we && (cfg_bank == 1'(l))),
                .set_idx   (cfg_idx),
                .set_val   (cfg_val),
                .mem_re    (re[l]),
                .mem_addr  (addr[l]),
                .mem_rdata (rdat[l]),
                .wb_en     (wbe[l]),
                .wb_pair   (wpair[l]),
                .wb_data   (wdat[l]),
                .err       (err[l])
            );
            pl_pairfile u_file (
                .clk     (clk),
                .rst_n   (rst_n),
                .wb_en   (wbe[l]),
                .wb_pair (wpair[l]),
                .wb_data (wdat[l]),
                .rd_idx  (ridx[l]),
                .rd_data (rout[l])
            );
        end
    endgenerate

    assign a_mem_re   = re[0];   assign b_mem_re   = re[1];
    assign a_mem_addr = addr[0]; assign b_mem_addr = addr[1];
    assign a_err      = err[0];  assign b_err      = err[1];
    assign a_rd_data  = rout[0]; assign b_rd_data  = rout[1];

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_err, wbe[0]}) && $onehot0({b_err, wbe[1]})) else $error("err with fill"); // R5
endmodule

// File: tb/pl_dual_load_bench.sv
`timescale 1ns/10ps
module pl_dual_load_bench;
    localparam int AW = 12;
    localparam logic [AW-1:0] TOP = '1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cfg_we = 0, cfg_bank = 0;
    logic [1:0] cfg_idx = 0;
    logic [AW-1:0] cfg_val = 0;
    logic iss [2] = '{0, 0};
    logic [2:0] dst [2] = '{0, 0};
    logic [1:0] sel [2] = '{0, 0};
    logic [1:0] mdf [2] = '{0, 0};
    logic a_mem_re, b_mem_re, a_err, b_err;
    logic [AW-1:0] a_mem_addr, b_mem_addr;
    logic [31:0] a_mem_rdata = 0, b_mem_rdata = 0;
    logic [2:0] a_rd_idx = 0, b_rd_idx = 0;
    logic [15:0] a_rd_data, b_rd_data;

    pl_dual_load #(.AW(AW)) u_pl_dual_load (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .a_issue(iss[0]), .a_dst(dst[0]), .a_ptr(sel[0]), .a_mod(mdf[0]),
        .b_issue(iss[1]), .b_dst(dst[1]), .b_ptr(sel[1]), .b_mod(mdf[1]),
        .a_mem_re(a_mem_re), .a_mem_addr(a_mem_addr), .a_mem_rdata(a_mem_rdata),
        .b_mem_re(b_mem_re), .b_mem_addr(b_mem_addr), .b_mem_rdata(b_mem_rdata),
        .a_err(a_err), .b_err(b_err),
        .a_rd_idx(a_rd_idx), .a_rd_data(a_rd_data),
        .b_rd_idx(b_rd_idx), .b_rd_data(b_rd_data));

    function automatic logic [31:0] word_at(logic [AW-1:0] a, int bank);
        return (32'(a) * 32'h9E3779B1) ^ (bank == 1 ? 32'h5A5A_C3C3 : 32'h0F0F_0001);
    endfunction

    function automatic bit dst_ok(logic [2:0] d);
        return (d[0] == 1'b0) && (d <= 3'd4);
    endfunction

    // Memory banks: one-cycle read latency on the core port.
    always @(posedge clk) begin
        if (a_mem_re) a_mem_rdata <= word_at(a_mem_addr, 0);
        if (b_mem_re) b_mem_rdata <= word_at(b_mem_addr, 1);
    end

    int errors = 0, checks = 0;
    bit done = 0;
    logic [AW-1:0] mp [2][4];
    logic [15:0]   mr [2][6];
    bit            pv [2];
    int            pp [2];
    logic [31:0]   pd [2];
    bit            me [2];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(int l, bit i, logic [2:0] d, logic [1:0] s, logic [1:0] m);
        iss[l] = i; dst[l] = d; sel[l] = s; mdf[l] = m;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic cycle(string tag);
        #0.5;
        for (int l = 0; l < 2; l++) begin
            logic re_v; logic [AW-1:0] ad_v;
            bit ok;
            re_v = (l == 0) ? a_mem_re : b_mem_re;
            ad_v = (l == 0) ? a_mem_addr : b_mem_addr;
            ok = iss[l] && dst_ok(dst[l]);
            chk(re_v == ok, "R2/R5", {tag, " mem_re"}, re_v, ok);
            if (ok) chk(ad_v == mp[l][sel[l]], "R2", {tag, " mem_addr"}, ad_v, mp[l][sel[l]]);
        end
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            bit ok;
            if (pv[l]) begin
                mr[l][pp[l]*2]   = pd[l][15:0];
                mr[l][pp[l]*2+1] = pd[l][31:16];
            end
            ok = iss[l] && dst_ok(dst[l]);
            pv[l] = ok;
            pp[l] = int'(dst[l]) / 2;
            pd[l] = word_at(mp[l][sel[l]], l);
            me[l] = iss[l] && !ok;
            if (ok && mdf[l] == 2'b01) mp[l][sel[l]] = mp[l][sel[l]] + 1'b1;
            if (ok && mdf[l] == 2'b10) mp[l][sel[l]] = mp[l][sel[l]] - 1'b1;
            if (cfg_we && int'(cfg_bank) == l) mp[l][cfg_idx] = cfg_val;
        end
        #1;
        chk(a_err == me[0], "R5", {tag, " a_err"}, a_err, me[0]);
        chk(b_err == me[1], "R5", {tag, " b_err"}, b_err, me[1]);
        for (int r = 0; r < 6; r++) begin
            a_rd_idx = 3'(r); b_rd_idx = 3'(r);
            #0.1;
            chk(a_rd_data == mr[0][r], "R3/R9", {tag, " A reg"}, a_rd_data, mr[0][r]);
            chk(b_rd_data == mr[1][r], "R6/R9", {tag, " B reg"}, b_rd_data, mr[1][r]);
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic setup(int bank, logic [1:0] idx, logic [AW-1:0] val);
        cfg_we = 1; cfg_bank = 1'(bank); cfg_idx = idx; cfg_val = val;
    endtask

    task automatic idle_all();
        drive(0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int l = 0; l < 2; l++) begin
            pv[l] = 0; me[l] = 0;
            for (int p = 0; p < 4; p++) mp[l][p] = '0;
            for (int r = 0; r < 6; r++) mr[l][r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(a_mem_re == 0 && b_mem_re == 0, "R1", "mem_re after reset", {a_mem_re, b_mem_re}, 0);
        chk(a_err == 0 && b_err == 0, "R1", "err after reset", {a_err, b_err}, 0);
        chk(a_mem_addr == 0, "R1", "pointer after reset", a_mem_addr, 0);
        idle_all(); cycle("R1 idle");

        // R3 example: pointer 0x23c into pair 2/3
        setup(0, 2'd0, AW'(12'h23c)); cycle("R7 setup");
        drive(0, 1, 3'd2, 2'd0, 2'b00); cycle("R3 example");
        idle_all(); cycle("R3 example wb");
        chk(mp[0][0] == AW'(12'h23c), "R4", "no-modify pointer", mp[0][0], 12'h23c);

        // R4 wrap: top + 1 -> 0, 0 - 1 -> top
        setup(1, 2'd3, TOP); cycle("R7 setup top");
        drive(1, 1, 3'd4, 2'd3, 2'b01); cycle("R4 wrap inc");
        drive(1, 1, 3'd0, 2'd3, 2'b10); cycle("R4 dec from 0");
        drive(1, 1, 3'd2, 2'd3, 2'b11); cycle("R4 hold code");
        idle_all(); cycle("R4 drain");

        // R5 every illegal code on both lanes
        for (int d = 1; d < 8; d += 2) begin
            drive(0, 1, 3'(d), 2'd1, 2'b01); drive(1, 1, 3'(d), 2'd2, 2'b10);
            cycle("R5 odd dst");
        end
        drive(0, 1, 3'd6, 2'd0, 2'b01); drive(1, 1, 3'd6, 2'd0, 2'b01); cycle("R5 dst 6");
        idle_all(); cycle("R5 drain");

        // R7 setup collides with post-modify
        drive(0, 1, 3'd0, 2'd2, 2'b01); setup(0, 2'd2, AW'(12'h555)); cycle("R7 collision");
        drive(0, 1, 3'd4, 2'd2, 2'b10); cycle("R7 use setup value");

        // R8 back-to-back into different pairs, R6 both lanes
        drive(0, 1, 3'd0, 2'd1, 2'b01); drive(1, 1, 3'd4, 2'd1, 2'b01); cycle("R8 b2b 1");
        drive(0, 1, 3'd2, 2'd1, 2'b01); drive(1, 1, 3'd2, 2'd1, 2'b10); cycle("R8 b2b 2");
        drive(0, 1, 3'd4, 2'd1, 2'b01); drive(1, 1, 3'd0, 2'd1, 2'b10); cycle("R8 b2b 3");
        idle_all(); cycle("R8 drain");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            for (int l = 0; l < 2; l++) begin
                logic [2:0] d;
                d = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                                 : 3'(2 * $urandom_range(0, 2));
                drive(l, ($urandom_range(0, 4) != 0), d, 2'($urandom_range(0, 3)),
                      2'($urandom_range(0, 3)));
            end
            if ($urandom_range(0, 5) == 0)
                setup($urandom_range(0, 1), 2'($urandom_range(0, 3)), AW'($urandom));
            cycle("R6 random");
        end
        idle_all(); cycle("final drain");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule